// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the architectural register store of a processor that passes procedure arguments in registers. Software always sees 32 logical registers, addressed with 5 bits. Behind them sits a larger physical file of 74 entries. A window pointer selects which slice of that file the logical addresses reach.

Logical registers 0 to 9 are global and reach the same storage from every window. The remaining 22 logical registers are split three ways. Logical 10 to 15 are the incoming set, shared with the calling window. Logical 16 to 25 are private locals. Logical 26 to 31 are the outgoing set, shared with the called window. A call pulse moves the pointer one window forward, so the caller's outgoing set becomes the callee's incoming set with no copy. A return pulse moves it back.

The four windows form a ring. A call-depth counter tracks how many windows are live, and one-cycle pulses report when a call or a return crosses the limits of that ring. Moving live data to and from memory is left to the surrounding logic.

Top module: `rwin_file`

## Requirements
- R1: While reset is high and on the first cycle after it, the window pointer is 0 and both limit pulses are 0.
- R2: Logical addresses 0 to 9 reach physical entries 0 to 9 in every window, so a global written from any window reads back the same from all windows.
- R3: For window pointer P and logical address A from 10 to 31, the physical entry is 10 + ((A − 10 + 16·P) mod 64). All 74 physical entries are distinct storage.
- R4: Logical 26 to 31 of window P are the same storage as logical 10 to 15 of window (P+1) mod 4. This includes window 3, whose outgoing set is the incoming set of window 0.
- R5: Logical 16 to 25 of each window reach storage that no other window can address.
- R6: A call alone advances the pointer to (P+1) mod 4 on the next clock edge. A return alone sets it to (P+3) mod 4.
- R7: A call made while the depth counter is at its maximum of 3 still moves the pointer and raises the overflow pulse for exactly one cycle after the edge. A call made below that depth leaves the pulse low.
- R8: A return made at depth 0 still moves the pointer and raises the underflow pulse for exactly one cycle after the edge.
- R9: Call and return asserted together leave the pointer and the depth unchanged and raise no pulse.
- R10: Reads are combinational and the write lands on the clock edge. A read of the entry being written in the same cycle returns the old value, and the new value from the next cycle on.
- R11: The two read ports decode their addresses independently, and each returns the entry selected by its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Procedure call: advance window pointer |
| ret_req | input | 1 | Procedure return: step window pointer back |
| ra_addr | input | 5 | Read port A logical address |
| ra_data | output | 32 | Read port A data (combinational) |
| rb_addr | input | 5 | Read port B logical address |
| rb_data | output | 32 | Read port B data (combinational) |
| we | input | 1 | Write enable |
| wa_addr | input | 5 | Write logical address, mapped through the current window |
| wa_data | input | 32 | Write data |
| win_ptr | output | 2 | Current window pointer |
| win_ovf | output | 1 | One-cycle pulse: call made at full depth |
| win_unf | output | 1 | One-cycle pulse: return made at zero depth |

## Verification
On every cycle, the assertions check the following: globals map to themselves, every mapped index stays inside the file, the pointer steps by exactly one window per call or return and holds otherwise, the limit pulses follow the depth counter and never coincide, and a written entry reads back its data on the next cycle. They cannot show that the overlap sets of neighbouring windows actually alias, or that the locals are private. That needs the bench's scenario: it fills every window with distinct stamps, wraps the ring in both directions, and sweeps all 32 addresses of each window on both ports against a model of the storage. The bench also covers reading an entry in the same cycle it is written, and a call and return asserted together.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  typedef enum logic [1:0] {
    WOP_HOLD = 2'd0,
    WOP_CALL = 2'd1,
    WOP_RET  = 2'd2
  } win_op_e;

  function automatic int rw_phys_count(input int g, input int l, input int c, input int w);
    return g + (l + c) * w;
  endfunction

  function automatic int rw_logical_count(input int g, input int l, input int c);
    return g + l + 2 * c;
  endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map #(
  parameter int GLOBALS = 10,
  parameter int LOCALS  = 10,
  parameter int SHARED  = 6,
  parameter int WINDOWS = 4,
  parameter int LA_W    = 5,
  parameter int PA_W    = 7,
  parameter int PTR_W   = 2
) (
  input  logic [LA_W-1:0]  laddr,
  input  logic [PTR_W-1:0] ptr,
  output logic [PA_W-1:0]  paddr
);
  localparam int STRIDE = LOCALS + SHARED;
  localparam int SPAN   = STRIDE * WINDOWS;
  localparam int NPHYS  = rwin_pkg::rw_phys_count(GLOBALS, LOCALS, SHARED, WINDOWS);

  int off;

  always_comb begin
    off = 0;
    if (int'(laddr) < GLOBALS) begin
      paddr = PA_W'(int'(laddr));
    end else begin
      off = int'(laddr) - GLOBALS + STRIDE * int'(ptr);
      if (off >= SPAN) off = off - SPAN;
      paddr = PA_W'(GLOBALS + off);
    end
  end

  // Checks against the pointer and address, not against off.
  always_comb begin
    if (!$isunknown({laddr, ptr})) begin
      if (int'(laddr) < GLOBALS)
        assert_global_fixed_R2: assert (int'(paddr) == int'(laddr));
      assert_index_in_file_R3: assert (int'(paddr) < NPHYS);
      if (int'(laddr) >= GLOBALS)
        assert_window_region_R3: assert (int'(paddr) >= GLOBALS);
    end
  end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int WINDOWS = 4,
  parameter int PTR_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic             ret_req,
  output logic [PTR_W-1:0] ptr,
  output logic             ovf,
  output logic             unf
);
  import rwin_pkg::*;

  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(WINDOWS - 1);
  localparam logic [PTR_W-1:0] DEPTH_MAX = PTR_W'(WINDOWS - 1);

  win_op_e          op;
  logic [PTR_W-1:0] depth;

  always_comb begin
    case ({call_req, ret_req})
      2'b10:   op = WOP_CALL;
      2'b01:   op = WOP_RET;
      default: op = WOP_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      case (op)
        WOP_CALL: begin
          ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
          if (depth == DEPTH_MAX) ovf <= 1'b1;
          else depth <= depth + 1'b1;
        end
        WOP_RET: begin
          ptr <= (ptr == '0) ? PTR_LAST : ptr - 1'b1;
          if (depth == '0) unf <= 1'b1;
          else depth <= depth - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_call_step_R6: assert property (@(posedge clk) disable iff (rst)
    (op == WOP_CALL) |=> (ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)));

  assert_ret_step_R6: assert property (@(posedge clk) disable iff (rst)
    (op == WOP_RET) |=> (ptr == (($past(ptr) == '0) ? PTR_LAST : $past(ptr) - 1'b1)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(op) == WOP_CALL && $past(depth) == DEPTH_MAX));

  assert_full_call_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (op == WOP_CALL && depth == DEPTH_MAX) |=> ovf);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    unf |-> ($past(op) == WOP_RET && $past(depth) == '0));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (op == WOP_HOLD) |=> ($stable(ptr) && $stable(depth) && !ovf && !unf));

  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DATA_W = 32,
  parameter int NPHYS  = 74,
  parameter int PA_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PA_W-1:0]   wa_paddr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic [PA_W-1:0]   ra_paddr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [PA_W-1:0]   rb_paddr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [NPHYS];

  // No reset on the array so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wa_paddr] <= wa_data;
  end

  assign ra_data = mem[ra_paddr];
  assign rb_data = mem[rb_paddr];

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && ra_paddr == $past(wa_paddr)) |-> (ra_data == $past(wa_data)));

  assert_ports_agree_R11: assert property (@(posedge clk) disable iff (rst)
    (ra_paddr == rb_paddr) |-> (ra_data == rb_data));

endmodule

// File: rtl/rwin_file.sv
module rwin_file #(
  parameter int DATA_W      = 32,
  parameter int NUM_GLOBALS = 10,
  parameter int NUM_LOCALS  = 10,
  parameter int NUM_SHARED  = 6,
  parameter int NUM_WINDOWS = 4,
  localparam int NLOG  = rwin_pkg::rw_logical_count(NUM_GLOBALS, NUM_LOCALS, NUM_SHARED),
  localparam int NPHYS = rwin_pkg::rw_phys_count(NUM_GLOBALS, NUM_LOCALS, NUM_SHARED, NUM_WINDOWS),
  localparam int LA_W  = $clog2(NLOG),
  localparam int PA_W  = $clog2(NPHYS),
  localparam int PTR_W = (NUM_WINDOWS > 1) ? $clog2(NUM_WINDOWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [LA_W-1:0]   ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [LA_W-1:0]   rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [LA_W-1:0]   wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  output logic [PTR_W-1:0]  win_ptr,
  output logic              win_ovf,
  output logic              win_unf
);
  localparam int NPORTS = 3;

  logic [LA_W-1:0] la [NPORTS];
  logic [PA_W-1:0] pa [NPORTS];

  assign la[0] = wa_addr;
  assign la[1] = ra_addr;
  assign la[2] = rb_addr;

  rwin_ctrl #(
    .WINDOWS (NUM_WINDOWS),
    .PTR_W   (PTR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .call_req (call_req),
    .ret_req  (ret_req),
    .ptr      (win_ptr),
    .ovf      (win_ovf),
    .unf      (win_unf)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    rwin_map #(
      .GLOBALS (NUM_GLOBALS),
      .LOCALS  (NUM_LOCALS),
      .SHARED  (NUM_SHARED),
      .WINDOWS (NUM_WINDOWS),
      .LA_W    (LA_W),
      .PA_W    (PA_W),
      .PTR_W   (PTR_W)
    ) u_map (
      .laddr (la[p]),
      .ptr   (win_ptr),
      .paddr (pa[p])
    );
  end

  rwin_store #(
    .DATA_W (DATA_W),
    .NPHYS  (NPHYS),
    .PA_W   (PA_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .wa_paddr (pa[0]),
    .wa_data  (wa_data),
    .ra_paddr (pa[1]),
    .ra_data  (ra_data),
    .rb_paddr (pa[2]),
    .rb_data  (rb_data)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (win_ptr == '0 && !win_ovf && !win_unf));

endmodule

// File: tb/rwin_file_test.sv
module rwin_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_req = 1'b0, ret_req = 1'b0, we = 1'b0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wa_addr = '0;
  logic [31:0] wa_data = '0;
  logic [31:0] ra_data, rb_data;
  logic [1:0]  win_ptr;
  logic        win_ovf, win_unf;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model [74];

  always #4 clk = ~clk;

  rwin_file uut (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .we(we), .wa_addr(wa_addr), .wa_data(wa_data),
    .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  function automatic int phys(input int w, input int l);
    int off;
    if (l < 10) return l;
    off = l - 10 + 16 * w;
    if (off >= 64) off = off - 64;
    return 10 + off;
  endfunction

  function automatic string tag_of(input int l);
    if (l < 10) return "R2 R3";
    if (l < 16 || l > 25) return "R3 R4";
    return "R3 R5";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input logic c, input logic r);
    call_req = c;
    ret_req  = r;
    tick();
    call_req = 1'b0;
    ret_req  = 1'b0;
  endtask

  task automatic sweep(input int w);
    for (int l = 0; l < 32; l++) begin
      ra_addr = 5'(l);
      rb_addr = 5'(31 - l);
      #1;
      check(ra_data == model[phys(w, l)], tag_of(l), ra_data, model[phys(w, l)]);
      check(rb_data == model[phys(w, 31 - l)], "R11", rb_data, model[phys(w, 31 - l)]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old;
    repeat (3) tick();
    check(win_ptr == 2'd0 && !win_ovf && !win_unf, "R1", {29'd0, win_ptr, win_ovf}, 32'd0);
    rst = 1'b0;
    tick();
    check(win_ptr == 2'd0 && !win_ovf && !win_unf, "R1", {29'd0, win_ptr, win_ovf}, 32'd0);

    // Fill each window in call order; later windows overwrite shared entries.
    for (int w = 0; w < 4; w++) begin
      check(win_ptr == 2'(w), "R6", 32'(win_ptr), 32'(w));
      for (int l = 0; l < 32; l++) begin
        d = {8'hA5, 8'(w), 8'h3C, 8'(l)};
        we = 1'b1; wa_addr = 5'(l); wa_data = d;
        tick();
        model[phys(w, l)] = d;
      end
      we = 1'b0;
      if (w < 3) begin
        step(1'b1, 1'b0);
        check(!win_ovf, "R7", 32'(win_ovf), 32'd0);
      end
    end

    // Depth 3: next call wraps to window 0 and flags overflow.
    step(1'b1, 1'b0);
    check(win_ptr == 2'd0, "R6", 32'(win_ptr), 32'd0);
    check(win_ovf == 1'b1, "R7", 32'(win_ovf), 32'd1);
    sweep(0);
    tick();
    check(win_ovf == 1'b0, "R7", 32'(win_ovf), 32'd0);

    // Return across the ring boundary, then unwind to depth 0.
    step(1'b0, 1'b1);
    check(win_ptr == 2'd3 && !win_unf, "R6", 32'(win_ptr), 32'd3);
    sweep(3);
    step(1'b0, 1'b1);
    check(win_ptr == 2'd2 && !win_unf, "R6", 32'(win_ptr), 32'd2);
    sweep(2);
    step(1'b0, 1'b1);
    check(win_ptr == 2'd1 && !win_unf, "R6", 32'(win_ptr), 32'd1);
    sweep(1);
    step(1'b0, 1'b1);
    check(win_ptr == 2'd0, "R8", 32'(win_ptr), 32'd0);
    check(win_unf == 1'b1, "R8", 32'(win_unf), 32'd1);
    tick();
    check(win_unf == 1'b0, "R8", 32'(win_unf), 32'd0);

    // Simultaneous call and return.
    step(1'b1, 1'b1);
    check(win_ptr == 2'd0 && !win_ovf && !win_unf, "R9", {29'd0, win_ptr, win_ovf}, 32'd0);
    step(1'b1, 1'b0);
    check(win_ptr == 2'd1 && !win_ovf, "R9", 32'(win_ptr), 32'd1);
    step(1'b0, 1'b1);
    check(win_ptr == 2'd0 && !win_unf, "R9", 32'(win_ptr), 32'd0);

    // Same-cycle write and read.
    old = model[phys(0, 20)];
    ra_addr = 5'd20;
    we = 1'b1; wa_addr = 5'd20; wa_data = 32'hDEAD_0020;
    #1;
    check(ra_data == old, "R10", ra_data, old);
    tick();
    we = 1'b0;
    model[phys(0, 20)] = 32'hDEAD_0020;
    #1;
    check(ra_data == 32'hDEAD_0020, "R10", ra_data, 32'hDEAD_0020);
    sweep(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule